// File: doc/BRIEF.md
# Interval Timer Counter Channel

This block is a single 16-bit down-counting timer channel. A register interface elsewhere in the chip hands it a complete initial count, a 3-bit operating mode and a binary/decimal select through a one-cycle load strobe. The channel then counts on each cycle in which the timer clock enable is high. A gate input either pauses counting or triggers a restart, depending on the mode. The channel drives a single output waveform and shows its live count at all times, so the interface logic can latch or read it.

Six behaviours are supported:
- a terminal-count flag;
- a gate-triggered one-shot;
- a periodic rate pulse;
- a square wave;
- a single strobe started by the load (software-triggered);
- a single strobe started by a gate edge (hardware-triggered).

The count can run in plain binary or in four decimal digits. An initial count of zero gives the full range of the selected number system. The non-periodic modes wrap at zero instead of stopping.

Top module: `interval_timer_channel`

## Requirements
- R1: After reset, count_o is 0 and out_o is 0, and ticks change nothing until the first load.
- R2: A load sets count_o to load_count_i on the next cycle. out_o becomes 1 for modes 1 and 3 and becomes 0 for all other modes.
- R3: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R4: An initial count of 0 means 65536 ticks in binary or 10000 ticks in decimal. In modes 0, 1, 4 and 5, a tick at count 0 wraps the count to 16'hFFFF in binary or 16'h9999 in decimal.
- R5: In decimal mode, each 4-bit digit counts from 9 down to 0 and then borrows from the next digit up (16'h0100 becomes 16'h0099).
- R6: Mode 0: the count decrements while gate_i is high. out_o goes to 1 on the tick that brings the count to 0 and then stays at 1 until the next load.
- R7: Mode 1: counting waits for a rising edge of gate_i. That edge reloads the initial count and drives out_o to 0. out_o returns to 1 when the count reaches 0. A later rising edge retriggers the channel.
- R8: Mode 2: with N as the initial count, out_o is 1 for one tick interval every N ticks. The first pulse comes on the Nth tick, and the count reloads to N at that same tick. A rising edge of gate_i restarts the count at N with out_o at 0.
- R9: Mode 3 (N of 2 or more): the count falls by 2 per tick. out_o is 1 for (N+1)/2 ticks and 0 for N/2 ticks (integer division), and the phases repeat.
- R10: Mode 4: the count decrements while gate_i is high. out_o is 1 for exactly one tick interval, starting at the tick that first brings the count to 0.
- R11: Mode 5: no counting happens before a rising edge of gate_i. Each rising edge reloads N and re-arms a single one-tick strobe on out_o when the count reaches 0.
- R12: The count holds whenever tick_en is low and no load or trigger occurs. In modes 0, 2, 3 and 4, gate_i low also holds the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer clock enable, one tick per high cycle |
| gate_i | input | 1 | Gate level (enable) and rising-edge trigger |
| load_i | input | 1 | One-cycle strobe that loads count, mode and number system |
| load_count_i | input | 16 | Initial count (0 means full range) |
| load_mode_i | input | 3 | Operating mode code 0 to 7 |
| load_bcd_i | input | 1 | 1 selects decimal counting, 0 selects binary |
| count_o | output | 16 | Live count value |
| out_o | output | 1 | Channel output waveform |

## Verification
The bench drives decimal counts through a borrow across a digit and a wrap from zero. A design that treated the digits as binary would show 16'h00FF or 16'hFFFF instead. It runs a decimal zero count for the full 10000 ticks to confirm the full-range reading, where an off-by-one design would flag one tick early or late. An odd square-wave count checks the uneven high and low phases, which a design that splits the period evenly would get wrong. The bench also checks the single-tick strobes in modes 4 and 5 against wrap: a design without a once-only guard would leave the output high or would repeat the strobe. Finally, it checks that a sustained gate level alone never starts modes 1 and 5, since a design that triggered on level rather than edge would begin counting at once.

// File: rtl/itc_pkg.sv
package itc_pkg;

  typedef enum logic [2:0] {
    TM_TERMFLAG = 3'd0,
    TM_ONESHOT  = 3'd1,
    TM_RATE     = 3'd2,
    TM_SQUARE   = 3'd3,
    TM_SWSTROBE = 3'd4,
    TM_HWSTROBE = 3'd5
  } tmode_e;

  // codes 6 and 7 fold onto the two periodic modes
  function automatic tmode_e fold_mode(input logic [2:0] code);
    logic [2:0] m;
    m = (code[2] && code[1]) ? {1'b0, code[1:0]} : code;
    return tmode_e'(m);
  endfunction

endpackage

// File: rtl/itc_digit_dec.sv
// Subtract one from a value made of 4-bit digits; each digit underflows
// to 9 in decimal mode or to F in binary mode.
module itc_digit_dec #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             bcd_i,
  output logic [WIDTH-1:0] val_o
);
  localparam int NDIG = WIDTH / 4;

  logic [NDIG:0] borrow;
  logic [3:0]    top_digit;

  assign borrow[0] = 1'b1;
  assign top_digit = bcd_i ? 4'd9 : 4'hF;

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    logic [3:0] cur;
    assign cur = val_i[4*d +: 4];
    assign val_o[4*d +: 4] = !borrow[d]    ? cur :
                             (cur == 4'd0) ? top_digit : cur - 4'd1;
    assign borrow[d+1] = borrow[d] && (cur == 4'd0);
  end
endmodule

// File: rtl/itc_edge_det.sv
module itc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  assign rise_o = sig_i && !sig_q;
endmodule

// File: rtl/interval_timer_channel.sv
module interval_timer_channel
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_count_i,
  input  logic [2:0]       load_mode_i,
  input  logic             load_bcd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  tmode_e           mode_q, mode_d;
  logic             bcd_q, bcd_d;
  logic [CNT_W-1:0] init_q, init_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic             run_q, run_d;
  logic             armed_q, armed_d;
  logic             fired_q, fired_d;

  logic [CNT_W-1:0] dec1, dec2;
  logic             gate_rise;
  logic             at_one, half_end, retrig_mode, strobe_en;
  tmode_e           new_mode;

  itc_edge_det u_gate_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_i (gate_i),
    .rise_o(gate_rise)
  );

  itc_digit_dec #(.WIDTH(CNT_W)) u_dec_a (
    .val_i(cnt_q),
    .bcd_i(bcd_q),
    .val_o(dec1)
  );

  itc_digit_dec #(.WIDTH(CNT_W)) u_dec_b (
    .val_i(dec1),
    .bcd_i(bcd_q),
    .val_o(dec2)
  );

  assign new_mode    = fold_mode(load_mode_i);
  assign at_one      = (cnt_q == ONE);
  assign half_end    = (cnt_q == ONE) || (cnt_q == TWO);
  assign retrig_mode = (mode_q == TM_ONESHOT) || (mode_q == TM_RATE) ||
                       (mode_q == TM_SQUARE)  || (mode_q == TM_HWSTROBE);
  assign strobe_en   = (mode_q == TM_SWSTROBE) ? gate_i : armed_q;

  always_comb begin
    mode_d  = mode_q;
    bcd_d   = bcd_q;
    init_d  = init_q;
    cnt_d   = cnt_q;
    out_d   = out_q;
    run_d   = run_q;
    armed_d = armed_q;
    fired_d = fired_q;
    if (load_i) begin
      mode_d  = new_mode;
      bcd_d   = load_bcd_i;
      init_d  = load_count_i;
      cnt_d   = load_count_i;
      run_d   = 1'b1;
      armed_d = 1'b0;
      fired_d = 1'b0;
      out_d   = (new_mode == TM_ONESHOT) || (new_mode == TM_SQUARE);
    end else if (run_q && gate_rise && retrig_mode) begin
      cnt_d   = init_q;
      armed_d = 1'b1;
      fired_d = 1'b0;
      out_d   = (mode_q == TM_SQUARE);
    end else if (run_q && tick_en) begin
      case (mode_q)
        TM_TERMFLAG: begin
          if (gate_i) begin
            cnt_d = dec1;
            out_d = out_q || at_one;
          end
        end
        TM_ONESHOT: begin
          if (armed_q) begin
            cnt_d = dec1;
            out_d = out_q || at_one;
          end
        end
        TM_RATE: begin
          if (gate_i) begin
            cnt_d = at_one ? init_q : dec1;
            out_d = at_one;
          end else begin
            out_d = 1'b0;
          end
        end
        TM_SQUARE: begin
          if (gate_i) begin
            if (half_end) begin
              out_d = !out_q;
              cnt_d = out_q ? {init_q[CNT_W-1:1], 1'b0} : init_q;
            end else begin
              cnt_d = dec2;
            end
          end else begin
            out_d = 1'b1;
          end
        end
        TM_SWSTROBE, TM_HWSTROBE: begin
          if (strobe_en) begin
            cnt_d   = dec1;
            out_d   = at_one && !fired_q;
            fired_d = fired_q || at_one;
          end else begin
            out_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= TM_TERMFLAG;
      bcd_q   <= 1'b0;
      init_q  <= '0;
      cnt_q   <= '0;
      out_q   <= 1'b0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      bcd_q   <= bcd_d;
      init_q  <= init_d;
      cnt_q   <= cnt_d;
      out_q   <= out_d;
      run_q   <= run_d;
      armed_q <= armed_d;
      fired_q <= fired_d;
    end
  end

  assign count_o = cnt_q;
  assign out_o   = out_q;

  // R2
  load_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_o == $past(load_count_i)));

  // R3
  mode_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_mode_i == 3'd6) |=> (mode_q == TM_RATE));

  // R12
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_i && !gate_rise) |=> $stable(count_o));

  // R6
  termflag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TM_TERMFLAG && out_q && !load_i) |=> out_q);

  // R7
  oneshot_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TM_ONESHOT && run_q && gate_rise && !load_i) |=> !out_q);

  // R8
  rate_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TM_RATE && $rose(out_q)) |-> (cnt_q == init_q));

  // R10
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == TM_SWSTROBE || mode_q == TM_HWSTROBE) && out_q && tick_en && !load_i)
      |=> !out_q);

endmodule

// File: tb/tb_interval_timer_channel.sv
module tb_interval_timer_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        gate_i;
  logic        load_i;
  logic [15:0] load_count_i;
  logic [2:0]  load_mode_i;
  logic        load_bcd_i;
  logic [15:0] count_o;
  logic        out_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  interval_timer_channel dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_i(gate_i),
    .load_i(load_i), .load_count_i(load_count_i), .load_mode_i(load_mode_i),
    .load_bcd_i(load_bcd_i), .count_o(count_o), .out_o(out_o)
  );

  task automatic chk(input string req, input logic [15:0] ec, input logic eo);
    n_tests++;
    if (count_o !== ec || out_o !== eo) begin
      n_fail++;
      $display("FAIL %s: count=%h out=%b expected count=%h out=%b",
               req, count_o, out_o, ec, eo);
    end
  endtask

  task automatic do_load(input logic [2:0] m, input logic [15:0] n, input logic b);
    @(negedge clk);
    load_i = 1'b1; load_mode_i = m; load_count_i = n; load_bcd_i = b;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  task automatic set_gate(input logic v);
    gate_i = v;
    @(negedge clk);
  endtask

  task automatic pulse_gate();
    set_gate(1'b0);
    set_gate(1'b1);
  endtask

  task automatic t_reset();
    chk("R1", 16'h0000, 1'b0);
    ticks(3);
    chk("R1", 16'h0000, 1'b0);
  endtask

  task automatic t_mode0();
    do_load(3'd0, 16'd5, 1'b0);
    chk("R2", 16'd5, 1'b0);
    ticks(4);
    chk("R6", 16'd1, 1'b0);
    ticks(1);
    chk("R6", 16'd0, 1'b1);
    ticks(1);
    chk("R4", 16'hFFFF, 1'b1);
    set_gate(1'b0);
    ticks(2);
    chk("R12", 16'hFFFF, 1'b1);
    set_gate(1'b1);
  endtask

  task automatic t_decimal();
    do_load(3'd0, 16'h0100, 1'b1);
    ticks(1);
    chk("R5", 16'h0099, 1'b0);
    do_load(3'd0, 16'h0000, 1'b1);
    ticks(1);
    chk("R4", 16'h9999, 1'b0);
    ticks(9998);
    chk("R4", 16'h0001, 1'b0);
    ticks(1);
    chk("R4", 16'h0000, 1'b1);
    ticks(1);
    chk("R5", 16'h9999, 1'b1);
  endtask

  task automatic t_mode1();
    do_load(3'd1, 16'd3, 1'b0);
    chk("R2", 16'd3, 1'b1);
    ticks(2);
    chk("R7", 16'd3, 1'b1);
    pulse_gate();
    chk("R7", 16'd3, 1'b0);
    ticks(2);
    chk("R7", 16'd1, 1'b0);
    ticks(1);
    chk("R7", 16'd0, 1'b1);
    ticks(1);
    chk("R4", 16'hFFFF, 1'b1);
    pulse_gate();
    chk("R7", 16'd3, 1'b0);
  endtask

  task automatic t_mode2();
    do_load(3'd2, 16'd4, 1'b0);
    chk("R2", 16'd4, 1'b0);
    ticks(3);
    chk("R8", 16'd1, 1'b0);
    ticks(1);
    chk("R8", 16'd4, 1'b1);
    ticks(1);
    chk("R8", 16'd3, 1'b0);
    ticks(3);
    chk("R8", 16'd4, 1'b1);
    ticks(1);
    set_gate(1'b0);
    ticks(2);
    chk("R12", 16'd3, 1'b0);
    set_gate(1'b1);
    chk("R8", 16'd4, 1'b0);
    do_load(3'd6, 16'd2, 1'b0);
    ticks(1);
    chk("R3", 16'd1, 1'b0);
    ticks(1);
    chk("R3", 16'd2, 1'b1);
  endtask

  task automatic t_mode3();
    do_load(3'd7, 16'd5, 1'b0);
    chk("R3", 16'd5, 1'b1);
    ticks(1);
    chk("R9", 16'd3, 1'b1);
    ticks(1);
    chk("R9", 16'd1, 1'b1);
    ticks(1);
    chk("R9", 16'd4, 1'b0);
    ticks(1);
    chk("R9", 16'd2, 1'b0);
    ticks(1);
    chk("R9", 16'd5, 1'b1);
    do_load(3'd3, 16'd6, 1'b0);
    ticks(2);
    chk("R9", 16'd2, 1'b1);
    ticks(1);
    chk("R9", 16'd6, 1'b0);
    ticks(2);
    chk("R9", 16'd2, 1'b0);
    ticks(1);
    chk("R9", 16'd6, 1'b1);
  endtask

  task automatic t_mode4();
    do_load(3'd4, 16'd3, 1'b0);
    chk("R2", 16'd3, 1'b0);
    ticks(2);
    chk("R10", 16'd1, 1'b0);
    ticks(1);
    chk("R10", 16'd0, 1'b1);
    ticks(1);
    chk("R10", 16'hFFFF, 1'b0);
    set_gate(1'b0);
    ticks(1);
    chk("R12", 16'hFFFF, 1'b0);
    set_gate(1'b1);
  endtask

  task automatic t_mode5();
    do_load(3'd5, 16'd2, 1'b0);
    ticks(2);
    chk("R11", 16'd2, 1'b0);
    pulse_gate();
    chk("R11", 16'd2, 1'b0);
    ticks(1);
    chk("R11", 16'd1, 1'b0);
    ticks(1);
    chk("R11", 16'd0, 1'b1);
    ticks(1);
    chk("R11", 16'hFFFF, 1'b0);
    pulse_gate();
    chk("R11", 16'd2, 1'b0);
    ticks(2);
    chk("R11", 16'd0, 1'b1);
  endtask

  task automatic t_no_tick();
    do_load(3'd0, 16'd9, 1'b0);
    repeat (5) @(negedge clk);
    chk("R12", 16'd9, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; gate_i = 1'b1; load_i = 1'b0;
    load_count_i = '0; load_mode_i = '0; load_bcd_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_decimal();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    t_no_tick();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule